// File: doc/BRIEF.md
# Endpoint Buffer CPU Access Port

This block gives a processor access to the data buffers of a USB device controller. There are six endpoint buffers. Endpoint 0, the control endpoint, has a data register of its own. The five data endpoints (1 to 5) share a second data register. A select register, which keeps its value until it is rewritten, decides which data endpoint the shared register reaches. Any data endpoint can be handed over to DMA. While it is, the shared register neither reaches it nor changes it.

Each buffer is a byte FIFO with empty and full flags. Each data register has two mode bits of its own. One picks 8-bit or 16-bit access; a 16-bit access moves two bytes, lower byte first. The other turns on read-count mode, in which the latched received length falls as the processor reads. A control write to a register can also act on the endpoint that register currently reaches:
- validate only: marks the IN buffer ready so the bus side sends it as a short packet;
- clear only: empties the buffer;
- validate and clear together: empties the buffer and queues a zero-length packet.

A simple byte-wide bus-side port stands in for the serial engine. It pushes received bytes, marks the end of a received packet, and pops bytes to transmit.

Top module: `ep_fifo_port`

## Requirements
- R1: After reset every buffer is empty (not full), no ready or zero-length flag is set, both received lengths read 0, both ports are in 8-bit mode with read-count off, and the select register holds endpoint 1.
- R2: `cpu_port_sel`=0 addresses endpoint 0. `cpu_port_sel`=1 addresses the endpoint held in the select register. The select register keeps its value between accesses. A select write of 0, 6 or 7 leaves it unchanged.
- R3: When the selected endpoint has its `ep_dma` bit set, a shared-port write leaves its buffer unchanged. A shared-port read returns 0 and leaves its buffer unchanged.
- R4: In 8-bit mode each write stores `cpu_wdata[7:0]`, and each read returns the head byte in bits 7:0 with bits 15:8 zero. An empty buffer reads as 0.
- R5: In 16-bit mode each access moves two bytes: bits 7:0 are the earlier byte and bits 15:8 the later one. A read that finds only one byte returns it in bits 7:0 with bits 15:8 zero.
- R6: Each buffer holds DEPTH (64) bytes. `ep_full` is set at DEPTH bytes and `ep_empty` at zero bytes. Bytes written to a full buffer are dropped.
- R7: A control write with validate=1 and clear=0 sets the target's `ep_txrdy`. The flag drops when a pop empties that buffer.
- R8: A control write with clear=1 and validate=0 empties the target buffer. It also clears that buffer's ready flag, zero-length flag and received length.
- R9: A control write with validate=1 and clear=1 empties the target buffer and sets its `ep_zlp`. The next bus-side pop on that endpoint clears `ep_zlp`.
- R10: `bus_eop` latches the endpoint's current byte count as its received length. With read-count off, processor reads leave that length unchanged. With read-count on, each processor read lowers it by the number of bytes read.
- R11: Bytes leave a buffer in the order they entered it. `bus_rbyte` shows the head byte of `bus_ep`, or 0 if that buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe (pops the bytes shown on cpu_rdata) |
| cpu_port_sel | input | 1 | 0 = endpoint 0 register, 1 = shared register |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Head data of the addressed buffer |
| sel_we | input | 1 | Select register write strobe |
| sel_ep | input | EP_W | New select value (1 to NUM_EP-1) |
| ctl_we | input | 1 | Control write strobe |
| ctl_port | input | 1 | 0 = endpoint 0 register, 1 = shared register |
| ctl_valid | input | 1 | Validate action |
| ctl_clear | input | 1 | Clear action |
| ctl_wide | input | 1 | New width mode for the port (1 = 16-bit) |
| ctl_rcnt | input | 1 | New read-count mode for the port |
| ep_dma | input | NUM_EP | Per-endpoint DMA ownership (bit 0 unused) |
| bus_ep | input | EP_W | Endpoint addressed by the bus side |
| bus_push | input | 1 | Bus side stores bus_wbyte |
| bus_wbyte | input | 8 | Received byte |
| bus_eop | input | 1 | End of received packet |
| bus_pop | input | 1 | Bus side takes the head byte |
| bus_rbyte | output | 8 | Head byte for the bus side |
| ep_empty | output | NUM_EP | Buffer empty flags |
| ep_full | output | NUM_EP | Buffer full flags |
| ep_txrdy | output | NUM_EP | IN buffer handed to the bus side |
| ep_zlp | output | NUM_EP | Zero-length packet queued |
| ep0_len | output | LVL_W | Received length of endpoint 0 |
| sh_len | output | LVL_W | Received length of the selected endpoint |

## Verification
Some properties are checked on every cycle: the select register stays within the data endpoints; no buffer is full and empty at once; a full buffer stays full when nothing drains it; a DMA-owned target reads as zero and keeps its flags when the processor accesses it; and each control action sets or clears its flags one cycle later. Other behaviour only the bench's scenarios can show. This covers data order across the byte lanes in the two width modes, the odd trailing byte, dropped bytes at the depth limit, routing through the select register for every endpoint, and the arithmetic of the received-length count.

// File: rtl/epfa_pkg.sv
// Shared types for the endpoint buffer access port.
package epfa_pkg;
    // Which processor-side data register an access uses.
    typedef enum logic {
        PORT_EP0    = 1'b0,
        PORT_SHARED = 1'b1
    } port_e;

    // Per-register access mode.
    typedef struct packed {
        logic wide;   // 1: 16-bit access, two bytes per strobe
        logic rcnt;   // 1: reads lower the latched received length
    } port_mode_t;
endpackage

// File: rtl/epfa_buffer.sv
// One endpoint buffer: a byte FIFO that takes up to two pushes and two pops
// per cycle, with the packet flags and received length of one endpoint.
// Assumes DEPTH is a power of two, so the pointers wrap on their own.
// A flush wins over any push or pop made in the same cycle.
module epfa_buffer #(
    parameter  int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             arm_tx,
    input  logic             arm_zlp,
    input  logic [1:0]       push_n,
    input  logic [15:0]      push_data,
    input  logic [1:0]       pop_n,
    input  logic             cnt_dec,
    input  logic             eop,
    output logic [7:0]       head0,
    output logic [7:0]       head1,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] rx_len,
    output logic             txrdy,
    output logic             zlp
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] space, n_push, n_pop, push_req, pop_req;

    // Limit each request to the bytes and slots actually available.
    always_comb begin
        push_req = LVL_W'(push_n);
        pop_req  = LVL_W'(pop_n);
        space    = LVL_W'(DEPTH) - level;
        n_push   = (push_req > space) ? space : push_req;
        n_pop    = (pop_req > level) ? level : pop_req;
    end

    // Store the bytes that are accepted, lower byte first.
    always_ff @(posedge clk) begin
        if (!flush) begin
            if (n_push != '0)
                mem[wr_ptr] <= push_data[7:0];
            if (n_push == LVL_W'(2))
                mem[wr_ptr + PTR_W'(1)] <= push_data[15:8];
        end
    end

    // Move the pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(n_push);
            rd_ptr <= rd_ptr + PTR_W'(n_pop);
            level  <= level + n_push - n_pop;
        end
    end

    // Ready flag: set by validate, dropped when a pop empties the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)          txrdy <= 1'b0;
        else if (arm_tx)              txrdy <= 1'b1;
        else if (n_pop != '0 && n_pop == level) txrdy <= 1'b0;
    end

    // Zero-length flag: set by validate with clear, consumed by a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                   zlp <= 1'b0;
        else if (arm_zlp)             zlp <= 1'b1;
        else if (flush)               zlp <= 1'b0;
        else if (pop_n != 2'd0)       zlp <= 1'b0;
    end

    // Received length: latched at end of packet, counted down when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)          rx_len <= '0;
        else if (eop)                 rx_len <= level;
        else if (cnt_dec)             rx_len <= (rx_len > n_pop) ? rx_len - n_pop : '0;
    end

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + PTR_W'(1)];
endmodule

// File: rtl/epfa_port_ctl.sv
// Select register and the mode bits of the two processor data registers.
// The select register only takes data-endpoint numbers (1 to NUM_EP-1).
module epfa_port_ctl
    import epfa_pkg::*;
#(
    parameter  int NUM_EP = 6,
    localparam int EP_W   = $clog2(NUM_EP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_we,
    input  logic [EP_W-1:0] sel_ep,
    input  logic            ctl_we,
    input  logic            ctl_port,
    input  logic            ctl_wide,
    input  logic            ctl_rcnt,
    output logic [EP_W-1:0] sel_q,
    output port_mode_t      mode_ep0,
    output port_mode_t      mode_sh
);
    // Hold the shared-register target; ignore out-of-range values.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= EP_W'(1);
        else if (sel_we && int'(sel_ep) >= 1 && int'(sel_ep) < NUM_EP)
            sel_q <= sel_ep;
    end

    // Each control write reloads the mode bits of its own register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_ep0 <= '0;
            mode_sh  <= '0;
        end else if (ctl_we) begin
            if (ctl_port == PORT_SHARED) mode_sh  <= '{wide: ctl_wide, rcnt: ctl_rcnt};
            else                         mode_ep0 <= '{wide: ctl_wide, rcnt: ctl_rcnt};
        end
    end
endmodule

// File: rtl/ep_fifo_port.sv
// Processor access port for the endpoint buffers of a USB device.
// Endpoint 0 has its own register; the data endpoints share one register
// that is routed by the select register. The bus-side port is a byte-wide
// stand-in for the serial engine. Assumes the processor and the bus side
// do not touch the same endpoint in the same cycle (the processor wins).
module ep_fifo_port
    import epfa_pkg::*;
#(
    parameter  int NUM_EP = 6,
    parameter  int DEPTH  = 64,
    localparam int EP_W   = $clog2(NUM_EP),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_port_sel,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    input  logic              sel_we,
    input  logic [EP_W-1:0]   sel_ep,
    input  logic              ctl_we,
    input  logic              ctl_port,
    input  logic              ctl_valid,
    input  logic              ctl_clear,
    input  logic              ctl_wide,
    input  logic              ctl_rcnt,
    input  logic [NUM_EP-1:0] ep_dma,
    input  logic [EP_W-1:0]   bus_ep,
    input  logic              bus_push,
    input  logic [7:0]        bus_wbyte,
    input  logic              bus_eop,
    input  logic              bus_pop,
    output logic [7:0]        bus_rbyte,
    output logic [NUM_EP-1:0] ep_empty,
    output logic [NUM_EP-1:0] ep_full,
    output logic [NUM_EP-1:0] ep_txrdy,
    output logic [NUM_EP-1:0] ep_zlp,
    output logic [LVL_W-1:0]  ep0_len,
    output logic [LVL_W-1:0]  sh_len
);
    logic [EP_W-1:0]  sel_q;
    port_mode_t       mode_ep0, mode_sh;
    logic [7:0]       h0_a  [NUM_EP];
    logic [7:0]       h1_a  [NUM_EP];
    logic [LVL_W-1:0] lvl_a [NUM_EP];
    logic [LVL_W-1:0] rxl_a [NUM_EP];

    epfa_port_ctl #(.NUM_EP(NUM_EP)) u_ctl (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_ep(sel_ep),
        .ctl_we(ctl_we), .ctl_port(ctl_port), .ctl_wide(ctl_wide),
        .ctl_rcnt(ctl_rcnt), .sel_q(sel_q), .mode_ep0(mode_ep0), .mode_sh(mode_sh)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic       cpu_tgt, ctl_hit, bus_hit;
        port_mode_t m;
        logic [1:0] push_n, pop_n;
        logic [15:0] push_d;

        // Route processor, control and bus strobes to this endpoint.
        always_comb begin
            if (e == 0) begin
                cpu_tgt = (cpu_port_sel == PORT_EP0);
                ctl_hit = ctl_we && (ctl_port == PORT_EP0);
                m       = mode_ep0;
            end else begin
                cpu_tgt = (cpu_port_sel == PORT_SHARED) && int'(sel_q) == e && !ep_dma[e];
                ctl_hit = ctl_we && (ctl_port == PORT_SHARED) && int'(sel_q) == e;
                m       = mode_sh;
            end
            bus_hit = int'(bus_ep) == e;
            push_n  = (cpu_tgt && cpu_wr) ? (m.wide ? 2'd2 : 2'd1)
                                          : ((bus_hit && bus_push) ? 2'd1 : 2'd0);
            push_d  = (cpu_tgt && cpu_wr) ? cpu_wdata : {8'h00, bus_wbyte};
            pop_n   = (cpu_tgt && cpu_rd) ? (m.wide ? 2'd2 : 2'd1)
                                          : ((bus_hit && bus_pop) ? 2'd1 : 2'd0);
        end

        epfa_buffer #(.DEPTH(DEPTH)) u_buf (
            .clk(clk), .rst_n(rst_n),
            .flush(ctl_hit && ctl_clear),
            .arm_tx(ctl_hit && ctl_valid && !ctl_clear),
            .arm_zlp(ctl_hit && ctl_valid && ctl_clear),
            .push_n(push_n), .push_data(push_d), .pop_n(pop_n),
            .cnt_dec(cpu_tgt && cpu_rd && m.rcnt),
            .eop(bus_hit && bus_eop),
            .head0(h0_a[e]), .head1(h1_a[e]), .level(lvl_a[e]), .rx_len(rxl_a[e]),
            .txrdy(ep_txrdy[e]), .zlp(ep_zlp[e])
        );

        assign ep_empty[e] = (lvl_a[e] == '0);
        assign ep_full[e]  = (lvl_a[e] == LVL_W'(DEPTH));
    end

    // Processor read data: head bytes of the addressed buffer, zero-filled.
    always_comb begin
        logic [EP_W-1:0] idx;
        logic            wide;
        idx       = (cpu_port_sel == PORT_SHARED) ? sel_q : '0;
        wide      = (cpu_port_sel == PORT_SHARED) ? mode_sh.wide : mode_ep0.wide;
        cpu_rdata = '0;
        if (!((cpu_port_sel == PORT_SHARED) && ep_dma[sel_q])) begin
            if (lvl_a[idx] != '0)
                cpu_rdata[7:0] = h0_a[idx];
            if (wide && lvl_a[idx] >= LVL_W'(2))
                cpu_rdata[15:8] = h1_a[idx];
        end
    end

    // Bus-side head byte, zero when the buffer is empty or out of range.
    always_comb begin
        bus_rbyte = '0;
        if (int'(bus_ep) < NUM_EP && lvl_a[bus_ep] != '0)
            bus_rbyte = h0_a[bus_ep];
    end

    assign ep0_len = rxl_a[0];
    assign sh_len  = rxl_a[sel_q];
endmodule

// File: rtl/ep_fifo_port_chk.sv
// Cycle-by-cycle properties of the endpoint buffer access port, bound
// to every instance of the top module.
module ep_fifo_port_chk #(
    parameter  int NUM_EP = 6,
    parameter  int DEPTH  = 64,
    localparam int EP_W   = $clog2(NUM_EP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic              cpu_port_sel,
    input logic [15:0]       cpu_rdata,
    input logic              ctl_we,
    input logic              ctl_port,
    input logic              ctl_valid,
    input logic              ctl_clear,
    input logic [NUM_EP-1:0] ep_dma,
    input logic [EP_W-1:0]   bus_ep,
    input logic              bus_push,
    input logic              bus_pop,
    input logic [NUM_EP-1:0] ep_empty,
    input logic [NUM_EP-1:0] ep_full,
    input logic [NUM_EP-1:0] ep_txrdy,
    input logic [NUM_EP-1:0] ep_zlp,
    input logic [EP_W-1:0]   sel_q
);
    p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q != '0 && int'(sel_q) < NUM_EP);

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_empty & ep_full) == '0);

    p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_full[0] && !(cpu_rd && !cpu_port_sel) && !(bus_pop && bus_ep == '0) && !ctl_we)
        |=> ep_full[0]);

    p_dma_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_port_sel && ep_dma[sel_q]) |-> cpu_rdata == '0);

    p_dma_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_port_sel && ep_dma[sel_q] && (cpu_wr || cpu_rd) && !bus_push && !bus_pop && !ctl_we)
        |=> $stable(ep_empty) && $stable(ep_full));

    p_validate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_port && ctl_valid && !ctl_clear) |=> ep_txrdy[0]);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_port && !ctl_valid && ctl_clear)
        |=> ep_empty[0] && !ep_txrdy[0] && !ep_zlp[0]);

    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_port && ctl_valid && ctl_clear) |=> ep_zlp[0] && ep_empty[0]);
endmodule

bind ep_fifo_port ep_fifo_port_chk #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_port_sel(cpu_port_sel), .cpu_rdata(cpu_rdata), .ctl_we(ctl_we),
    .ctl_port(ctl_port), .ctl_valid(ctl_valid), .ctl_clear(ctl_clear),
    .ep_dma(ep_dma), .bus_ep(bus_ep), .bus_push(bus_push), .bus_pop(bus_pop),
    .ep_empty(ep_empty), .ep_full(ep_full), .ep_txrdy(ep_txrdy), .ep_zlp(ep_zlp),
    .sel_q(sel_q)
);

// File: tb/test_ep_fifo_port.sv
`timescale 1ns/1ps
module test_ep_fifo_port;
    localparam int NUM_EP = 6;
    localparam int DEPTH  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 0, cpu_rd = 0, cpu_port_sel = 0;
    logic [15:0] cpu_wdata = '0, cpu_rdata;
    logic        sel_we = 0;
    logic [2:0]  sel_ep = '0;
    logic        ctl_we = 0, ctl_port = 0, ctl_valid = 0, ctl_clear = 0, ctl_wide = 0, ctl_rcnt = 0;
    logic [5:0]  ep_dma = '0;
    logic [2:0]  bus_ep = '0;
    logic        bus_push = 0, bus_eop = 0, bus_pop = 0;
    logic [7:0]  bus_wbyte = '0, bus_rbyte;
    logic [5:0]  ep_empty, ep_full, ep_txrdy, ep_zlp;
    logic [6:0]  ep0_len, sh_len;
    int          tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    ep_fifo_port #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) i_ep_fifo_port (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic port, input logic [15:0] d);
        cpu_port_sel = port; cpu_wdata = d; cpu_wr = 1; tick(); cpu_wr = 0;
    endtask

    task automatic cpu_read(input logic port, output logic [15:0] d);
        cpu_port_sel = port; #1; d = cpu_rdata; cpu_rd = 1; tick(); cpu_rd = 0;
    endtask

    task automatic set_sel(input logic [2:0] e);
        sel_ep = e; sel_we = 1; tick(); sel_we = 0;
    endtask

    task automatic set_ctl(input logic port, input logic v, input logic c, input logic w, input logic r);
        ctl_port = port; ctl_valid = v; ctl_clear = c; ctl_wide = w; ctl_rcnt = r;
        ctl_we = 1; tick(); ctl_we = 0; ctl_valid = 0; ctl_clear = 0;
    endtask

    task automatic bus_put(input logic [2:0] e, input logic [7:0] b);
        bus_ep = e; bus_wbyte = b; bus_push = 1; tick(); bus_push = 0;
    endtask

    task automatic bus_take(input logic [2:0] e, output logic [7:0] b);
        bus_ep = e; #1; b = bus_rbyte; bus_pop = 1; tick(); bus_pop = 0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  b;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();

        // R1 reset state
        chk("R1 empty", ep_empty, 6'h3f);
        chk("R1 full", ep_full, 0);
        chk("R1 txrdy", ep_txrdy, 0);
        chk("R1 zlp", ep_zlp, 0);
        chk("R1 lens", {ep0_len, sh_len}, 0);
        cpu_port_sel = 0; #1; chk("R1 rdata", cpu_rdata, 0);

        // R6/R4 fill endpoint 0 to depth in 8-bit mode, then overfill
        for (int i = 0; i < DEPTH; i++) begin
            cpu_write(0, {8'hCC, pat(i)});
            if (i == DEPTH - 2) chk("R6 not full at depth-1", ep_full[0], 0);
        end
        chk("R6 full at depth", ep_full[0], 1);
        cpu_write(0, 16'h00EE);
        for (int i = 0; i < DEPTH; i++) begin
            cpu_read(0, d);
            chk($sformatf("R4 byte %0d", i), d, {8'h00, pat(i)});
        end
        chk("R6 overfill dropped, empty", ep_empty[0], 1);
        cpu_port_sel = 0; #1; chk("R4 empty reads 0", cpu_rdata, 0);

        // R5 16-bit words round trip
        set_ctl(0, 0, 0, 1, 0);
        for (int k = 0; k < 4; k++) cpu_write(0, 16'(16'h0102 + k * 16'h1357));
        for (int k = 0; k < 4; k++) begin
            cpu_read(0, d);
            chk("R5 word", d, 16'(16'h0102 + k * 16'h1357));
        end
        // R5 lower byte first: wide write, narrow reads
        cpu_write(0, 16'hA55A);
        set_ctl(0, 0, 0, 0, 0);
        cpu_read(0, d); chk("R5 low first", d, 16'h005A);
        cpu_read(0, d); chk("R5 high second", d, 16'h00A5);
        // R5 odd trailing byte
        cpu_write(0, 16'h0011); cpu_write(0, 16'h0022); cpu_write(0, 16'h0033);
        set_ctl(0, 0, 0, 1, 0);
        cpu_read(0, d); chk("R5 pair", d, 16'h2211);
        cpu_read(0, d); chk("R5 odd byte", d, 16'h0033);
        chk("R5 empty after", ep_empty[0], 1);
        set_ctl(0, 0, 0, 0, 0);

        // R2 select sweep over every data endpoint
        for (int e = 1; e < NUM_EP; e++) begin
            set_sel(3'(e));
            for (int j = 0; j < e; j++) cpu_write(1, 16'(e * 16 + j));
        end
        chk("R2 routing flags", ep_empty, 6'b000001);
        for (int e = NUM_EP - 1; e >= 1; e--) begin
            set_sel(3'(e));
            for (int j = 0; j < e; j++) begin
                cpu_read(1, d);
                chk($sformatf("R2 ep%0d byte %0d", e, j), d, 16'(e * 16 + j));
            end
            chk("R2 drained", ep_empty[e], 1);
        end
        set_sel(3); set_sel(0); set_sel(6); set_sel(7);
        cpu_write(1, 16'h0077);
        chk("R2 bad select ignored", ep_empty, 6'b110111);
        cpu_read(1, d); chk("R2 held select data", d, 16'h0077);

        // R3 DMA-owned endpoint is invisible to the shared register
        ep_dma = 6'b000100;
        set_sel(2);
        cpu_write(1, 16'h0099);
        chk("R3 write ignored", ep_empty[2], 1);
        bus_put(2, 8'h42);
        cpu_read(1, d);
        chk("R3 read zero", d, 0);
        chk("R3 read no pop", ep_empty[2], 0);
        bus_take(2, b); chk("R11 dma byte", b, 8'h42);
        ep_dma = '0;

        // R7/R11 validate and bus-side drain order
        set_sel(1);
        for (int j = 0; j < 3; j++) cpu_write(1, 16'(8'hA0 + j));
        set_ctl(1, 1, 0, 0, 0);
        chk("R7 ready set", ep_txrdy, 6'b000010);
        for (int j = 0; j < 3; j++) begin
            bus_take(1, b);
            chk("R11 order", b, 8'(8'hA0 + j));
            chk("R7 ready tracks drain", ep_txrdy[1], (j < 2) ? 1'b1 : 1'b0);
        end

        // R8 clear
        set_sel(4);
        for (int j = 0; j < 5; j++) cpu_write(1, 16'(j));
        set_ctl(1, 1, 0, 0, 0);
        chk("R7 ready ep4", ep_txrdy[4], 1);
        set_ctl(1, 0, 1, 0, 0);
        chk("R8 emptied", ep_empty[4], 1);
        chk("R8 ready cleared", ep_txrdy[4], 0);

        // R9 zero-length packet
        cpu_write(0, 16'h0001); cpu_write(0, 16'h0002);
        set_ctl(0, 1, 1, 0, 0);
        chk("R9 zlp set", ep_zlp, 6'b000001);
        chk("R9 emptied", ep_empty[0], 1);
        bus_take(0, b);
        chk("R9 zlp consumed", ep_zlp[0], 0);

        // R10 received length and countdown
        set_sel(5);
        for (int j = 0; j < 5; j++) bus_put(5, 8'(8'h50 + j));
        bus_ep = 5; bus_eop = 1; tick(); bus_eop = 0;
        chk("R10 latched", sh_len, 5);
        cpu_read(1, d); chk("R10 data0", d, 16'h0050);
        cpu_read(1, d); chk("R10 data1", d, 16'h0051);
        chk("R10 no count when off", sh_len, 5);
        set_ctl(1, 0, 0, 0, 1);
        cpu_read(1, d); chk("R10 data2", d, 16'h0052);
        chk("R10 count by one", sh_len, 4);
        set_ctl(1, 0, 0, 1, 1);
        cpu_read(1, d); chk("R10 wide data", d, 16'h5453);
        chk("R10 count by two", sh_len, 2);
        set_ctl(1, 0, 1, 0, 0);
        chk("R8 length cleared", sh_len, 0);
        chk("R10 ep0 length untouched", ep0_len, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule